// File: doc/BRIEF.md
# Branch Direction Predictor Table

This block guesses the direction of conditional branches in an instruction fetch path and forms the address to fetch next. It keeps one small state record per table slot: a bit saying whether the slot has been trained, and a saturating two-bit confidence counter. A slot is picked from the halfword address of the branch, so branches whose addresses are 256 bytes apart share a slot.

The lookup side is purely combinational. Fetch presents the branch address, its sign-extended displacement and a flag for 2-byte encodings. In the same cycle it gets back a taken/not-taken guess and the predicted next address. A slot that has never been trained does not use its counter. Instead it falls back to a static rule: a negative displacement, meaning a loop-closing backward branch, is guessed taken.

Training happens at retirement. The retire stage gives the branch address, its encoding size and the address of the instruction that retired right after it. The block itself works out whether the branch was taken, by checking whether that follower is the fall-through address. The slot is then written on the next clock edge.

Top module: `branch_history_predictor`

## Requirements
- R1: After reset every slot is untrained, so each lookup follows the static rule of R2 until that slot has been trained.
- R2: For an untrained slot, the guess is taken exactly when bit 31 of the displacement is 1.
- R3: For a trained slot, the guess is taken exactly when the counter value is 2 or 3.
- R4: The next address is branch address plus displacement when the guess is taken. When the guess is not taken, it is branch address plus 2 if `lkp_short_i` is 1, and plus 4 otherwise. All sums wrap modulo 2^32.
- R5: A training event marks its slot trained. The first event on a fresh slot moves its counter from 0 to 1 if the branch was taken, so that slot then guesses not taken whatever the displacement sign.
- R6: A taken outcome adds 1 to the counter and stops at 3. A not-taken outcome subtracts 1 and stops at 0.
- R7: The outcome counts as taken when `upd_commit_next_i` differs from `upd_pc_i` plus the size (2 when `upd_short_i` is 1, else 4).
- R8: The slot is selected by address bits [7:1]. Bit 0 and bits above 7 do not affect the selection.
- R9: When a lookup and a training event select the same slot in the same cycle, the lookup reflects the state from before the training event. The new state is visible from the next cycle on.
- R10: With `upd_valid_i` at 0, no slot changes, whatever the other training inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_pc_i | input | 32 | Address of the branch being looked up |
| lkp_offset_i | input | 32 | Sign-extended branch displacement |
| lkp_short_i | input | 1 | 1 for a 2-byte encoding, 0 for a 4-byte one |
| lkp_taken_o | output | 1 | Direction guess |
| lkp_next_pc_o | output | 32 | Predicted next fetch address |
| upd_valid_i | input | 1 | A conditional branch retires this cycle |
| upd_pc_i | input | 32 | Address of the retiring branch |
| upd_short_i | input | 1 | 1 when the retiring branch is a 2-byte encoding |
| upd_commit_next_i | input | 32 | Address of the instruction retiring after the branch |

## Verification
The hardest case to reach is a lookup and a training event that land on the same slot in the same cycle, with the two requests using different addresses that alias. From the ports, this can only be seen as a guess that is still the old one for one cycle and changes in the next. The stimulus drives both sides together on an untrained slot, then on a trained slot whose counter is about to cross the taken threshold. It also uses aliasing addresses 256 bytes apart. The remaining corners are reached by explicit sequences: a 2-byte branch whose follower sits at the 4-byte fall-through, and counters held at both saturation ends. A long pseudo-random sequence over a few colliding addresses follows these.

// File: rtl/bhtp_pkg.sv
package bhtp_pkg;

    localparam int unsigned ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    // Training request after outcome resolution
    typedef struct packed {
        logic  vld;
        addr_t pc;
        logic  taken;
    } train_req_t;

    // Fall-through distance for a given encoding size
    function automatic addr_t fall_step(input logic is_short);
        return is_short ? addr_t'(2) : addr_t'(4);
    endfunction

endpackage

// File: rtl/bhtp_index.sv
module bhtp_index #(
    parameter int unsigned ENTRIES = 128,
    localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
    input  bhtp_pkg::addr_t   pc_i,
    output logic [IDX_W-1:0]  idx_o
);

    // Halfword address folded onto the table
    generate
        if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_pow2
            assign idx_o = pc_i[IDX_W:1];
        end else begin : g_modulo
            bhtp_pkg::addr_t half_addr;
            bhtp_pkg::addr_t folded;
            assign half_addr = {1'b0, pc_i[bhtp_pkg::ADDR_W-1:1]};
            assign folded    = half_addr % bhtp_pkg::addr_t'(ENTRIES);
            assign idx_o     = folded[IDX_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/bhtp_resolve.sv
module bhtp_resolve (
    input  logic                   vld_i,
    input  bhtp_pkg::addr_t        pc_i,
    input  logic                   is_short_i,
    input  bhtp_pkg::addr_t        follower_i,
    output bhtp_pkg::train_req_t   req_o
);

    bhtp_pkg::addr_t fall_thru;

    always_comb begin
        fall_thru   = pc_i + bhtp_pkg::fall_step(is_short_i);
        req_o.vld   = vld_i;
        req_o.pc    = pc_i;
        // Any follower other than the sequential one means the branch went
        req_o.taken = (follower_i != fall_thru);
    end

endmodule

// File: rtl/bhtp_table.sv
module bhtp_table #(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned CTR_W   = 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  bhtp_pkg::train_req_t              req_i,
    input  logic [IDX_W-1:0]                  req_idx_i,
    output logic [ENTRIES-1:0]                valid_o,
    output logic [ENTRIES-1:0][CTR_W-1:0]     ctr_o
);

    localparam logic [CTR_W-1:0] CTR_TOP = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CTR_BOT = '0;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][CTR_W-1:0] ctr;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < ENTRIES; e++) begin
            if (req_i.vld && (req_idx_i == IDX_W'(e))) begin
                st_d.valid[e] = 1'b1;
                if (req_i.taken) begin
                    if (st_q.ctr[e] != CTR_TOP) begin
                        st_d.ctr[e] = st_q.ctr[e] + CTR_W'(1);
                    end
                end else begin
                    if (st_q.ctr[e] != CTR_BOT) begin
                        st_d.ctr[e] = st_q.ctr[e] - CTR_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign ctr_o   = st_q.ctr;

endmodule

// File: rtl/bhtp_lookup.sv
module bhtp_lookup #(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned CTR_W   = 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  bhtp_pkg::addr_t               pc_i,
    input  bhtp_pkg::addr_t               offset_i,
    input  logic                          is_short_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][CTR_W-1:0] ctr_i,
    output logic                          taken_o,
    output bhtp_pkg::addr_t               next_pc_o
);

    localparam logic [CTR_W-1:0] TAKE_AT = CTR_W'(1) << (CTR_W - 1);

    logic             slot_trained;
    logic [CTR_W-1:0] slot_ctr;
    logic             dyn_guess;
    logic             static_guess;

    always_comb begin
        slot_trained = valid_i[idx_i];
        slot_ctr     = ctr_i[idx_i];
        dyn_guess    = (slot_ctr >= TAKE_AT);
        static_guess = offset_i[bhtp_pkg::ADDR_W-1];
        taken_o      = slot_trained ? dyn_guess : static_guess;
        next_pc_o    = pc_i + (taken_o ? offset_i : bhtp_pkg::fall_step(is_short_i));
    end

endmodule

// File: rtl/branch_history_predictor.sv
module branch_history_predictor #(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned CTR_W   = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [31:0] lkp_pc_i,
    input  logic [31:0] lkp_offset_i,
    input  logic        lkp_short_i,
    output logic        lkp_taken_o,
    output logic [31:0] lkp_next_pc_o,
    input  logic        upd_valid_i,
    input  logic [31:0] upd_pc_i,
    input  logic        upd_short_i,
    input  logic [31:0] upd_commit_next_i
);

    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0]              lkp_idx;
    logic [IDX_W-1:0]              upd_idx;
    bhtp_pkg::train_req_t          train_req;
    logic [ENTRIES-1:0]            tbl_valid;
    logic [ENTRIES-1:0][CTR_W-1:0] tbl_ctr;

    bhtp_index #(.ENTRIES(ENTRIES)) lkp_index_i (
        .pc_i  (lkp_pc_i),
        .idx_o (lkp_idx)
    );

    bhtp_index #(.ENTRIES(ENTRIES)) upd_index_i (
        .pc_i  (upd_pc_i),
        .idx_o (upd_idx)
    );

    bhtp_resolve resolve_i (
        .vld_i      (upd_valid_i),
        .pc_i       (upd_pc_i),
        .is_short_i (upd_short_i),
        .follower_i (upd_commit_next_i),
        .req_o      (train_req)
    );

    bhtp_table #(.ENTRIES(ENTRIES), .CTR_W(CTR_W)) table_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (train_req),
        .req_idx_i (upd_idx),
        .valid_o   (tbl_valid),
        .ctr_o     (tbl_ctr)
    );

    bhtp_lookup #(.ENTRIES(ENTRIES), .CTR_W(CTR_W)) lookup_i (
        .pc_i       (lkp_pc_i),
        .offset_i   (lkp_offset_i),
        .is_short_i (lkp_short_i),
        .idx_i      (lkp_idx),
        .valid_i    (tbl_valid),
        .ctr_i      (tbl_ctr),
        .taken_o    (lkp_taken_o),
        .next_pc_o  (lkp_next_pc_o)
    );

endmodule

// File: rtl/bhtp_checker.sv
module bhtp_checker #(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned CTR_W   = 2
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic [31:0]                   lkp_pc_i,
    input logic [31:0]                   lkp_offset_i,
    input logic                          lkp_short_i,
    input logic                          lkp_taken_o,
    input logic [31:0]                   lkp_next_pc_o,
    input logic                          upd_valid_i,
    input logic [31:0]                   upd_pc_i,
    input logic [ENTRIES-1:0]            tbl_valid,
    input logic [ENTRIES-1:0][CTR_W-1:0] tbl_ctr
);

    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [31:0]      li_full, ui_full;
    logic [IDX_W-1:0] li, ui, ui_prev;
    logic [CTR_W-1:0] ctr_prev;

    assign li_full = (lkp_pc_i >> 1) % 32'(ENTRIES);
    assign ui_full = (upd_pc_i >> 1) % 32'(ENTRIES);
    assign li      = li_full[IDX_W-1:0];
    assign ui      = ui_full[IDX_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ui_prev  <= '0;
            ctr_prev <= '0;
        end else begin
            ui_prev  <= ui;
            ctr_prev <= tbl_ctr[ui];
        end
    end

    p_static_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tbl_valid[li] |-> (lkp_taken_o == lkp_offset_i[31]));

    p_trained_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tbl_valid[li] |-> (lkp_taken_o == (int'(tbl_ctr[li]) >= (1 << (CTR_W - 1)))));

    p_next_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lkp_next_pc_o == (lkp_taken_o ? (lkp_pc_i + lkp_offset_i)
                                      : (lkp_pc_i + (lkp_short_i ? 32'd2 : 32'd4))));

    p_marks_trained_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i |=> tbl_valid[ui_prev]);

    p_ctr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i |=> ((int'(tbl_ctr[ui_prev]) - int'(ctr_prev) <= 1) &&
                         (int'(ctr_prev) - int'(tbl_ctr[ui_prev]) <= 1)));

    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_valid_i |=> ($stable(tbl_valid) && $stable(tbl_ctr)));

endmodule

bind branch_history_predictor bhtp_checker #(.ENTRIES(ENTRIES), .CTR_W(CTR_W)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lkp_pc_i      (lkp_pc_i),
    .lkp_offset_i  (lkp_offset_i),
    .lkp_short_i   (lkp_short_i),
    .lkp_taken_o   (lkp_taken_o),
    .lkp_next_pc_o (lkp_next_pc_o),
    .upd_valid_i   (upd_valid_i),
    .upd_pc_i      (upd_pc_i),
    .tbl_valid     (tbl_valid),
    .tbl_ctr       (tbl_ctr)
);

// File: tb/branch_history_predictor_tb_top.sv
module branch_history_predictor_tb_top;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] lkp_pc_i = '0;
    logic [31:0] lkp_offset_i = '0;
    logic        lkp_short_i = 1'b0;
    logic        lkp_taken_o;
    logic [31:0] lkp_next_pc_o;
    logic        upd_valid_i = 1'b0;
    logic [31:0] upd_pc_i = '0;
    logic        upd_short_i = 1'b0;
    logic [31:0] upd_commit_next_i = '0;

    always #10 clk = ~clk;

    branch_history_predictor dut_i (
        .clk_i             (clk),
        .rst_ni            (rst_ni),
        .lkp_pc_i          (lkp_pc_i),
        .lkp_offset_i      (lkp_offset_i),
        .lkp_short_i       (lkp_short_i),
        .lkp_taken_o       (lkp_taken_o),
        .lkp_next_pc_o     (lkp_next_pc_o),
        .upd_valid_i       (upd_valid_i),
        .upd_pc_i          (upd_pc_i),
        .upd_short_i       (upd_short_i),
        .upd_commit_next_i (upd_commit_next_i)
    );

    typedef struct {
        logic        taken;
        logic [31:0] next;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    // Reference state built from the requirements
    bit ref_trained[128];
    int ref_ctr[128];

    function automatic int slot_of(input logic [31:0] pc);
        return int'(pc[7:1]);   // R8
    endfunction

    task automatic step(input logic [31:0] pc, input logic [31:0] off, input logic shrt,
                        input logic uv, input logic [31:0] upc, input logic ushrt,
                        input logic [31:0] unext, input string req);
        exp_t e;
        int   s;
        logic tk;
        @(negedge clk);
        lkp_pc_i = pc; lkp_offset_i = off; lkp_short_i = shrt;
        upd_valid_i = uv; upd_pc_i = upc; upd_short_i = ushrt; upd_commit_next_i = unext;
        s = slot_of(pc);
        e.taken = ref_trained[s] ? (ref_ctr[s] >= 2) : off[31];        // R2 R3
        e.next  = e.taken ? pc + off : pc + (shrt ? 32'd2 : 32'd4);    // R4
        e.req   = req;
        exp_q.push_back(e);
        if (uv) begin
            s  = slot_of(upc);
            tk = (unext != upc + (ushrt ? 32'd2 : 32'd4));             // R7
            ref_trained[s] = 1'b1;                                      // R5
            if (tk) ref_ctr[s] = (ref_ctr[s] < 3) ? ref_ctr[s] + 1 : 3; // R6
            else    ref_ctr[s] = (ref_ctr[s] > 0) ? ref_ctr[s] - 1 : 0;
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic [31:0] off, input logic shrt,
                        input string req);
        step(pc, off, shrt, 1'b0, 32'h0, 1'b0, 32'h0, req);
    endtask

    task automatic train(input logic [31:0] upc, input logic ushrt, input logic went,
                         input string req);
        logic [31:0] nx;
        nx = went ? upc + 32'h40 : upc + (ushrt ? 32'd2 : 32'd4);
        step(32'h0000_0F00, 32'h10, 1'b0, 1'b1, upc, ushrt, nx, req);
    endtask

    // Monitor: compares design outputs against the scoreboard mid low phase
    initial begin
        forever begin
            @(negedge clk);
            #4;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (lkp_taken_o !== e.taken) begin
                    n_fails++;
                    $display("FAIL %s taken: actual %0b expected %0b", e.req, lkp_taken_o, e.taken);
                end
                n_checks++;
                if (lkp_next_pc_o !== e.next) begin
                    n_fails++;
                    $display("FAIL %s next_pc: actual %h expected %h", e.req, lkp_next_pc_o, e.next);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < 128; i++) begin ref_trained[i] = 1'b0; ref_ctr[i] = 0; end
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;

        // R1 / R2: fresh table follows the displacement sign
        look(32'h0000_0100, 32'h0000_0040, 1'b0, "R1 forward untrained");
        look(32'h0000_0344, 32'hFFFF_FFF8, 1'b1, "R1 backward untrained");
        look(32'h0000_0500, 32'h8000_0000, 1'b0, "R2 min displacement");
        look(32'h0000_0504, 32'h7FFF_FFFE, 1'b1, "R2 max positive displacement");

        // R9: same-slot lookup and training in one cycle sees old state
        step(32'h0000_0100, 32'hFFFF_FF00, 1'b0, 1'b1, 32'h0000_0100, 1'b0, 32'h0000_0140,
             "R9 same cycle untrained");
        // R5: trained once taken -> counter 1 -> not taken despite backward offset
        look(32'h0000_0100, 32'hFFFF_FF00, 1'b0, "R5 first training");
        // R9 on a crossing: counter 1 -> 2 this cycle, lookup still sees 1
        step(32'h0000_0100, 32'hFFFF_FF00, 1'b0, 1'b1, 32'h0000_0100, 1'b0, 32'h0000_0140,
             "R9 same cycle at threshold");
        look(32'h0000_0100, 32'h0000_0020, 1'b0, "R3 counter two");
        // R6 upper saturation
        train(32'h0000_0100, 1'b0, 1'b1, "R6 to three");
        train(32'h0000_0100, 1'b0, 1'b1, "R6 beyond three");
        train(32'h0000_0100, 1'b0, 1'b0, "R6 down one");
        look(32'h0000_0100, 32'h0000_0020, 1'b1, "R6 held at three then two");
        train(32'h0000_0100, 1'b0, 1'b0, "R6 down to one");
        look(32'h0000_0100, 32'hFFFF_FFF0, 1'b1, "R3 counter one");
        // R6 lower saturation
        train(32'h0000_0100, 1'b0, 1'b0, "R6 to zero");
        train(32'h0000_0100, 1'b0, 1'b0, "R6 below zero");
        train(32'h0000_0100, 1'b0, 1'b1, "R6 up from zero");
        look(32'h0000_0100, 32'hFFFF_FFF0, 1'b0, "R6 zero floor held");

        // R8: aliasing 256 bytes apart, bit 0 ignored, neighbour slot independent
        look(32'h0000_0200, 32'hFFFF_FFF0, 1'b0, "R8 alias shares slot");
        look(32'h0000_0101, 32'hFFFF_FFF0, 1'b0, "R8 bit zero ignored");
        look(32'h0000_0102, 32'hFFFF_FFF0, 1'b0, "R8 neighbour untrained");

        // R10: idle training inputs pointing at a slot change nothing
        step(32'h0000_0F00, 32'h10, 1'b0, 1'b0, 32'h0000_0102, 1'b0, 32'h0000_0900, "R10 idle");
        look(32'h0000_0102, 32'hFFFF_FFF0, 1'b0, "R10 slot still untrained");

        // R7: 2-byte branch whose follower sits at +4 counts as taken
        train(32'h0000_0702, 1'b1, 1'b0, "R7 short fall-through");
        look(32'h0000_0702, 32'hFFFF_FFF0, 1'b1, "R7 short fall-through");
        step(32'h0000_0F00, 32'h10, 1'b0, 1'b1, 32'h0000_0702, 1'b1, 32'h0000_0706, "R7 short plus four");
        step(32'h0000_0F00, 32'h10, 1'b0, 1'b1, 32'h0000_0702, 1'b1, 32'h0000_0706, "R7 short plus four");
        look(32'h0000_0702, 32'h0000_0010, 1'b1, "R7 now taken");

        // Pseudo-random mix over a few colliding addresses
        lfsr = 32'hACE1_2345;
        for (int k = 0; k < 300; k++) begin
            logic [31:0] pcs [4];
            logic [31:0] lp, up, off, nx;
            logic        ls, us;
            pcs[0] = 32'h0000_1000; pcs[1] = 32'h0000_1100;
            pcs[2] = 32'h0000_1006; pcs[3] = 32'h0000_2FFE;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lp  = pcs[lfsr[1:0]];
            up  = pcs[lfsr[3:2]];
            ls  = lfsr[4];
            us  = lfsr[5];
            off = lfsr[6] ? 32'hFFFF_FF80 + {24'h0, lfsr[15:8]} : {24'h0, lfsr[15:8]};
            nx  = up + (us ? 32'd2 : 32'd4) + (lfsr[7] ? 32'd8 : 32'd0);
            step(lp, off, ls, lfsr[16], up, us, nx, "R3 R6 R9 mixed");
        end

        @(negedge clk);
        #8;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule